// File: doc/BRIEF.md
# Memory Word Address Counter with Direction-Dependent Wrap

This block keeps the word address for an 11-bit-addressed byte memory that sits behind a serial bus. The bus controller loads it in two pieces. The upper three bits come from the page bits of the device byte. The lower eight bits come from the address byte that follows. After each byte is transferred, the controller pulses a step strobe. The counter then advances to the next byte.

Where the counter wraps depends on the direction of the transfer. A write step only increments the 4-bit offset inside the 16-byte page, so a write that passes the end of a page continues at the start of the same page. A read step increments the full 11-bit address, so a read continues across page boundaries and wraps from 2047 to 0.

The register keeps its value between transactions, so a read with no address phase continues from one past the last byte accessed. A device byte that opens a read carries page bits, but it must not disturb the counter. For that reason, a high-part load marked as a read is ignored.

Top module: `waddr_ctr`

## Requirements
- R1: While `rst_n` is low, and on the first rising edge of `clk` after that, `addr` reads 0.
- R2: When `ld_hi`=1 and `dev_rd`=0 at a rising edge, `addr[10:8]` takes `hi_val`. The lower eight bits are untouched unless `ld_lo` is also 1.
- R3: When `ld_lo`=1 at a rising edge, `addr[7:0]` takes `lo_val`. The upper three bits are untouched unless a valid high load happens in the same cycle.
- R4: When `ld_hi`=1 and `dev_rd`=1, the high load has no effect. If no other strobe is active, `addr` keeps its value.
- R5: A step with `step_rd`=0 (write) increments only `addr[3:0]`, modulo 16, and leaves `addr[10:4]` unchanged. For example, 0x0FF steps to 0x0F0.
- R6: A step with `step_rd`=1 (read) increments the whole of `addr` modulo 2048. For example, 0x0FF steps to 0x100 and 0x7FF steps to 0x000.
- R7: When a valid load (R2 or R3) and `step` occur in the same cycle, the load applies and the step is discarded.
- R8: When there is no valid load and no step, `addr` holds its value for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_hi | input | 1 | Load strobe for the page bits from the device byte |
| dev_rd | input | 1 | Direction bit of the device byte; 1 suppresses `ld_hi` |
| hi_val | input | 3 | Page bits, loaded into addr[10:8] |
| ld_lo | input | 1 | Load strobe for the word-address byte |
| lo_val | input | 8 | Word-address byte, loaded into addr[7:0] |
| step | input | 1 | Advance after a byte transfer |
| step_rd | input | 1 | Direction of the step: 1 read (full wrap), 0 write (page wrap) |
| addr | output | 11 | Current word address |

## Verification
The hardest state to reach is a step taken from the last byte of a page, or from address 2047. There, the write rule and the read rule give different results. Random operation mixes reach it only rarely. The stimulus therefore places the counter on these addresses with directed loads, then steps in both directions and walks across them with long runs of steps. Random sequences biased toward steps cover the interleavings of loads, suppressed loads and steps, including strobes that arrive in the same cycle.

// File: rtl/waddr_ctr.sv
module waddr_ctr #(
  parameter int HI_W  = 3,
  parameter int LO_W  = 8,
  parameter int OFS_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_hi,
  input  logic                 dev_rd,
  input  logic [HI_W-1:0]      hi_val,
  input  logic                 ld_lo,
  input  logic [LO_W-1:0]      lo_val,
  input  logic                 step,
  input  logic                 step_rd,
  output logic [HI_W+LO_W-1:0] addr
);
  localparam int AW = HI_W + LO_W;

  logic [AW-1:0] cur;
  logic          armed;

  wire              hi_take  = ld_hi & ~dev_rd;
  wire              any_ld   = hi_take | ld_lo;
  wire [AW-1:0]     rd_next  = cur + AW'(1);
  wire [OFS_W-1:0]  ofs_next = cur[OFS_W-1:0] + OFS_W'(1);
  wire [AW-1:0]     wr_next  = {cur[AW-1:OFS_W], ofs_next};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (any_ld) begin
      if (hi_take) cur[AW-1:LO_W] <= hi_val;
      if (ld_lo)   cur[LO_W-1:0]  <= lo_val;
    end else if (step) begin
      cur <= step_rd ? rd_next : wr_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign addr = cur;

  assert_hi_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(ld_hi && !dev_rd)) |-> addr[AW-1:LO_W] == $past(hi_val));

  assert_lo_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(ld_lo)) |-> addr[LO_W-1:0] == $past(lo_val));

  assert_rd_dev_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(ld_hi && dev_rd && !ld_lo && !step)) |-> addr == $past(addr));

  assert_write_page_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(step && !step_rd && !ld_lo && !(ld_hi && !dev_rd))) |->
      (addr[AW-1:OFS_W] == $past(addr[AW-1:OFS_W]) &&
       addr[OFS_W-1:0] == ($past(addr[OFS_W-1:0]) + OFS_W'(1))));

  assert_read_full_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(step && step_rd && !ld_lo && !(ld_hi && !dev_rd))) |->
      addr == ($past(addr) + AW'(1)));

  assert_load_beats_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(step && ld_lo && !ld_hi)) |->
      addr[AW-1:LO_W] == $past(addr[AW-1:LO_W]));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(!step && !ld_lo && !(ld_hi && !dev_rd))) |-> $stable(addr));
endmodule

// File: tb/sim_waddr_ctr.sv
module sim_waddr_ctr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_hi = 1'b0, dev_rd = 1'b0, ld_lo = 1'b0, step = 1'b0, step_rd = 1'b0;
  logic [2:0]  hi_val = '0;
  logic [7:0]  lo_val = '0;
  logic [10:0] addr;
  logic [10:0] exp_a = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  waddr_ctr u0 (.clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .dev_rd(dev_rd), .hi_val(hi_val),
                .ld_lo(ld_lo), .lo_val(lo_val), .step(step), .step_rd(step_rd), .addr(addr));

  function automatic logic [10:0] model(input logic [10:0] a, input logic lh, input logic dr,
      input logic [2:0] hv, input logic ll, input logic [7:0] lv, input logic st, input logic rd);
    logic [10:0] n = a;
    if ((lh && !dr) || ll) begin
      if (lh && !dr) n[10:8] = hv;
      if (ll) n[7:0] = lv;
    end else if (st) begin
      if (rd) n = a + 11'd1;
      else n = {a[10:4], 4'(a[3:0] + 4'd1)};
    end
    return n;
  endfunction

  task automatic check(input string rq);
    n_chk++;
    if (addr !== exp_a) begin
      n_bad++;
      $display("FAIL %s: addr=%h expected=%h", rq, addr, exp_a);
    end
  endtask

  task automatic op(input logic lh, input logic dr, input logic [2:0] hv, input logic ll,
                    input logic [7:0] lv, input logic st, input logic rd, input string rq);
    ld_hi = lh; dev_rd = dr; hi_val = hv; ld_lo = ll; lo_val = lv; step = st; step_rd = rd;
    exp_a = model(exp_a, lh, dr, hv, ll, lv, st, rd);
    @(negedge clk);
    ld_hi = 0; ld_lo = 0; step = 0;
    check(rq);
  endtask

  task automatic set_addr(input logic [10:0] a);
    op(1, 0, a[10:8], 1, a[7:0], 0, 0, "R2");
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    @(negedge clk); @(negedge clk);
    exp_a = '0;
    check("R1");
    rst_n = 1;
    @(negedge clk);
    check("R1");
    op(1, 0, 3'd5, 0, 8'h00, 0, 0, "R2");
    op(0, 0, 3'd0, 1, 8'hA7, 0, 0, "R3");
    op(1, 1, 3'd2, 0, 8'h00, 0, 0, "R4");
    op(0, 0, 3'd0, 0, 8'h00, 0, 0, "R8");
    for (int i = 0; i < 5; i++) op(0, 0, 0, 0, 0, 0, 0, "R8");
    set_addr(11'h0FF);
    op(0, 0, 0, 0, 0, 1, 0, "R5");
    set_addr(11'h7AF);
    op(0, 0, 0, 0, 0, 1, 0, "R5");
    for (int i = 0; i < 20; i++) op(0, 0, 0, 0, 0, 1, 0, "R5");
    set_addr(11'h0FF);
    op(0, 0, 0, 0, 0, 1, 1, "R6");
    set_addr(11'h7FF);
    op(0, 0, 0, 0, 0, 1, 1, "R6");
    set_addr(11'h7FD);
    for (int i = 0; i < 6; i++) op(0, 0, 0, 0, 0, 1, 1, "R6");
    op(0, 0, 0, 1, 8'h3C, 1, 1, "R7");
    op(1, 0, 3'd6, 0, 0, 1, 0, "R7");
    op(1, 1, 3'd1, 0, 0, 1, 1, "R4");
    op(1, 1, 3'd7, 1, 8'h11, 0, 0, "R4");
    for (int i = 0; i < 3000; i++) begin
      int unsigned k = $urandom_range(0, 9);
      logic lh = (k == 0) || (k == 1);
      logic dr = (k == 1) || ($urandom_range(0, 3) == 0);
      logic ll = (k == 2) || (k == 0 && $urandom_range(0, 1) == 1);
      logic st = (k >= 3 && k <= 8) || ($urandom_range(0, 7) == 0);
      logic rd = $urandom_range(0, 1) == 1;
      string rq;
      if ((lh && !dr) || ll) rq = st ? "R7" : (ll ? "R3" : "R2");
      else if (st) rq = rd ? "R6" : "R5";
      else rq = lh ? "R4" : "R8";
      op(lh, dr, 3'($urandom), ll, 8'($urandom), st, rd, rq);
    end
    rst_n = 0;
    exp_a = '0;
    @(negedge clk);
    check("R1");
    rst_n = 1;
    @(negedge clk);
    check("R1");
    done = 1;
    summary();
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: addr=%h expected=completion", addr);
      summary();
    end
  end
endmodule